// File: doc/BRIEF.md
# Directional Transform Mode Selector

This block sits beside the transform stage of an encoder that can run its two-dimensional DCT along several directions. For each 8x8 block, every candidate direction produces a quantized set of 64 coefficients. The selector counts the coefficients equal to zero in each candidate and reports the direction with the highest count, since a result with more zeros codes more cheaply. The transforms, the quantizer and the entropy coder are outside this block.

The directions are numbered 0, 2, 3, 4, 5, 6 and 7. Number 1 is unused. Direction 0 is the plain horizontal/vertical transform, 2 and 3 are the two diagonal directions, and 4 to 7 are the four semi-diagonal directions. A two-bit group input limits which directions take part. A candidate is streamed as 64 contiguous coefficients, one per cycle. Each coefficient carries a direction tag and a valid flag, and the 64th carries a last flag. The candidates of one block may arrive in any order. The group input is held steady from the first coefficient of a block until its result appears.

Top module: `xmp_top`

## Requirements
- R1: A candidate's zero count is the number of its 64 coefficients equal to zero, in the range 0 to 64, reported on a 7-bit output.
- R2: The reported direction is the enabled candidate with the highest zero count, and the reported count is that candidate's count.
- R3: When enabled candidates tie on zero count, the lower direction number wins.
- R4: Group input 0 enables direction 0 only. Value 1 enables directions 0, 2 and 3. Values 2 and 3 enable all seven directions.
- R5: Coefficients tagged with a direction outside the enabled group, or tagged 1, are ignored. They change neither the result nor the timing of the done strobe.
- R6: Within one block, a second candidate for a direction that has already completed is ignored.
- R7: The done strobe is high for exactly one cycle: the cycle after the last flag of the final enabled candidate of the block is sampled. This holds whatever order the candidates arrive in.
- R8: The direction and count outputs keep their values between done strobes.
- R9: After reset, done is low, the direction output is 0, the count output is 0, and no candidate counts as completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| grp_sel | input | 2 | Candidate group: 0 plain only, 1 plain plus diagonal, 2 or 3 all |
| cf_valid | input | 1 | A coefficient is present this cycle |
| cf_mode | input | 3 | Direction the coefficient belongs to |
| cf_data | input | 12 | Quantized coefficient, signed |
| cf_last | input | 1 | Marks the 64th coefficient of a candidate |
| pick_valid | output | 1 | One-cycle done strobe |
| pick_mode | output | 3 | Chosen direction |
| pick_zeros | output | 7 | Zero count of the chosen direction |

## Verification
Some properties are checked by assertions on every cycle. The done strobe never lasts two cycles, and the outputs stay frozen between strobes. A reported count never exceeds 64, and the reported direction is never 1. A candidate's last flag always falls on its 64th accepted coefficient. Within a block, the running best count never decreases. Other behaviour can only be shown by the bench's scenarios, because each needs a whole block's history: which direction wins, the tie order, the effect of each group setting, the rejection of stray and repeated candidates, and the exact cycle of the strobe when candidates arrive out of order.

// File: rtl/xmp_pkg.sv
// Shared widths, types and the group-to-candidate mapping for the
// directional transform mode selector. Bit i of a mask stands for mode i.
package xmp_pkg;
    localparam int MODE_W = 3;
    localparam int NSLOT  = 1 << MODE_W;

    typedef logic [MODE_W-1:0] mode_t;
    typedef logic [NSLOT-1:0]  slot_mask_t;

    typedef enum logic [1:0] {
        GRP_PLAIN = 2'd0,
        GRP_DIAG  = 2'd1,
        GRP_FULL  = 2'd2,
        GRP_FULL2 = 2'd3
    } grp_e;

    // Enabled candidate set for a group code; mode 1 never appears.
    function automatic slot_mask_t group_mask(input logic [1:0] g);
        case (grp_e'(g))
            GRP_PLAIN: return slot_mask_t'(8'b0000_0001);
            GRP_DIAG:  return slot_mask_t'(8'b0000_1101);
            default:   return slot_mask_t'(8'b1111_1101);
        endcase
    endfunction
endpackage

// File: rtl/xmp_zero_tally.sv
// Counts zero coefficients of the candidate currently streaming.
// Assumes accepted coefficients of one candidate are contiguous and that
// the last flag comes with the NCOEF-th of them. cnt_final already
// includes the coefficient presented this cycle.
module xmp_zero_tally #(
    parameter int NCOEF  = 64,
    parameter int COEF_W = 12,
    localparam int CNT_W = $clog2(NCOEF + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              last,
    input  logic [COEF_W-1:0] coef,
    output logic [CNT_W-1:0]  cnt_final
);
    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] idx;

    // Count including the coefficient on the input this cycle.
    always_comb cnt_final = run_cnt + CNT_W'(coef == '0);

    // Running zero count and coefficient index, cleared at each candidate end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            idx     <= '0;
        end else if (take) begin
            run_cnt <= last ? '0 : cnt_final;
            idx     <= last ? '0 : idx + 1'b1;
        end
    end

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= CNT_W'(NCOEF));

    assert_last_on_final_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (take && last) |-> (idx == CNT_W'(NCOEF - 1)));
endmodule

// File: rtl/xmp_best_track.sv
// Keeps the best candidate of the current block. A new candidate replaces
// the best when it has more zeros, or equal zeros and a lower mode number.
// win_* gives the result including the candidate completing this cycle.
// 'clear' ends the block and empties the tracker.
module xmp_best_track #(
    parameter int CNT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cand_done,
    input  logic              clear,
    input  xmp_pkg::mode_t    cand_mode,
    input  logic [CNT_W-1:0]  cand_zeros,
    output xmp_pkg::mode_t    win_mode,
    output logic [CNT_W-1:0]  win_zeros
);
    logic              have_best;
    xmp_pkg::mode_t    best_mode;
    logic [CNT_W-1:0]  best_zeros;
    logic              beats;

    // Ranking: more zeros first, then lower mode number.
    always_comb begin
        beats = !have_best
             || (cand_zeros > best_zeros)
             || ((cand_zeros == best_zeros) && (cand_mode < best_mode));
        win_mode  = beats ? cand_mode  : best_mode;
        win_zeros = beats ? cand_zeros : best_zeros;
    end

    // Best-so-far registers for the open block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_best  <= 1'b0;
            best_mode  <= '0;
            best_zeros <= '0;
        end else if (cand_done) begin
            if (clear) begin
                have_best  <= 1'b0;
                best_mode  <= '0;
                best_zeros <= '0;
            end else begin
                have_best  <= 1'b1;
                best_mode  <= win_mode;
                best_zeros <= win_zeros;
            end
        end
    end

    assert_best_monotonic_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_done && !clear && have_best) |=> (best_zeros >= $past(best_zeros)));
endmodule

// File: rtl/xmp_top.sv
// Directional transform mode selector. Accepts candidate coefficient
// streams for the enabled group, tracks which modes have completed, and
// emits the winner one cycle after the final enabled candidate ends.
// Assumes grp_sel is steady for the duration of a block.
module xmp_top #(
    parameter int NCOEF  = 64,
    parameter int COEF_W = 12,
    localparam int CNT_W = $clog2(NCOEF + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        grp_sel,
    input  logic              cf_valid,
    input  logic [2:0]        cf_mode,
    input  logic [COEF_W-1:0] cf_data,
    input  logic              cf_last,
    output logic              pick_valid,
    output logic [2:0]        pick_mode,
    output logic [CNT_W-1:0]  pick_zeros
);
    import xmp_pkg::*;

    slot_mask_t       en_mask, fin_mask, fin_next;
    logic [NSLOT-1:0] slot_ok;
    logic             accept, cand_done, block_end;
    logic [CNT_W-1:0] cnt_final, win_zeros;
    mode_t            win_mode;

    // Decide whether this coefficient belongs to an open, enabled candidate.
    always_comb begin
        en_mask   = group_mask(grp_sel);
        accept    = cf_valid && en_mask[cf_mode] && !fin_mask[cf_mode];
        cand_done = accept && cf_last;
        fin_next  = fin_mask | (cand_done ? (slot_mask_t'(1) << cf_mode) : '0);
    end

    // Per-slot completion check: disabled or finished.
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign slot_ok[s] = !en_mask[s] || fin_next[s];
    end

    always_comb block_end = cand_done && (&slot_ok);

    xmp_zero_tally #(.NCOEF(NCOEF), .COEF_W(COEF_W)) u_tally (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (accept),
        .last      (cf_last),
        .coef      (cf_data),
        .cnt_final (cnt_final)
    );

    xmp_best_track #(.CNT_W(CNT_W)) u_best (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand_done  (cand_done),
        .clear      (block_end),
        .cand_mode  (cf_mode),
        .cand_zeros (cnt_final),
        .win_mode   (win_mode),
        .win_zeros  (win_zeros)
    );

    // Completed-mode mask, emptied when the block closes.
    always_ff @(posedge clk) begin
        if (!rst_n) fin_mask <= '0;
        else        fin_mask <= block_end ? '0 : fin_next;
    end

    // Output registers: strobe plus held result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pick_valid <= 1'b0;
            pick_mode  <= '0;
            pick_zeros <= '0;
        end else begin
            pick_valid <= block_end;
            if (block_end) begin
                pick_mode  <= win_mode;
                pick_zeros <= win_zeros;
            end
        end
    end

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |=> !pick_valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pick_valid |-> ($stable(pick_mode) && $stable(pick_zeros)));

    assert_zero_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> (pick_zeros <= CNT_W'(NCOEF)));

    assert_no_mode1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> (pick_mode != 3'd1));
endmodule

// File: tb/sim_xmp_top.sv
// Scoreboard bench: the driver predicts each block's winner and queues it;
// the monitor compares every done strobe against the queue.
module sim_xmp_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  grp_sel = 2'd0;
    logic        cf_valid = 1'b0;
    logic [2:0]  cf_mode = 3'd0;
    logic [11:0] cf_data = 12'd0;
    logic        cf_last = 1'b0;
    logic        pick_valid;
    logic [2:0]  pick_mode;
    logic [6:0]  pick_zeros;

    int tests = 0;
    int fails = 0;
    int unsigned cyc = 0;
    bit finished = 1'b0;

    typedef struct packed {
        logic [2:0]  m;
        logic [6:0]  z;
        logic [31:0] c;
    } exp_t;
    exp_t  q_exp[$];
    string q_tag[$];

    // bench model of the open block
    logic [7:0] b_en, b_fin;
    logic       b_have;
    logic [2:0] b_m;
    logic [6:0] b_z;
    logic [2:0] last_m = 3'd0;
    logic [6:0] last_z = 7'd0;

    xmp_top u0 (
        .clk(clk), .rst_n(rst_n), .grp_sel(grp_sel), .cf_valid(cf_valid),
        .cf_mode(cf_mode), .cf_data(cf_data), .cf_last(cf_last),
        .pick_valid(pick_valid), .pick_mode(pick_mode), .pick_zeros(pick_zeros)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic start_block(input logic [1:0] g);
        @(negedge clk);
        grp_sel = g;
        case (g)   // R4 group encoding
            2'd0:    b_en = 8'b0000_0001;
            2'd1:    b_en = 8'b0000_1101;
            default: b_en = 8'b1111_1101;
        endcase
        b_fin = 8'd0;
        b_have = 1'b0;
        b_m = 3'd0;
        b_z = 7'd0;
    endtask

    // Stream one candidate of 64 coefficients with nz zeros scattered.
    task automatic send_cand(input logic [2:0] m, input int nz, input int seed, input string tag);
        bit ok;
        ok = b_en[m] && !b_fin[m];
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            cf_valid = 1'b1;
            cf_mode  = m;
            cf_last  = (k == 63);
            if (((k * 37 + seed) % 64) < nz) cf_data = 12'd0;
            else cf_data = (k % 2) ? -12'(k + 1) : 12'(k + 1);
            if (k == 63 && ok) begin
                b_fin[m] = 1'b1;
                if (!b_have || 7'(nz) > b_z || (7'(nz) == b_z && m < b_m)) begin
                    b_m = m;
                    b_z = 7'(nz);
                end
                b_have = 1'b1;
                if ((b_fin & b_en) == b_en) begin
                    q_exp.push_back('{m: b_m, z: b_z, c: cyc + 1});
                    q_tag.push_back(tag);
                    last_m = b_m;
                    last_z = b_z;
                end
            end
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        cf_valid = 1'b0;
        cf_last  = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops the scoreboard on each strobe, flags missed/extra ones.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (pick_valid) begin
                if (q_exp.size() == 0) begin
                    check("R7/R5 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    string t;
                    e = q_exp.pop_front();
                    t = q_tag.pop_front();
                    check({t, " mode"}, pick_mode, e.m);
                    check({t, " zeros"}, pick_zeros, e.z);
                    check({t, " R7 done cycle"}, cyc, e.c);
                end
            end else if (q_exp.size() != 0 && cyc > q_exp[0].c) begin
                check({q_tag[0], " R7 missed done"}, 0, 1);
                void'(q_exp.pop_front());
                void'(q_tag.pop_front());
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset valid", pick_valid, 0);
        check("R9 reset mode", pick_mode, 0);
        check("R9 reset zeros", pick_zeros, 0);
        rst_n = 1'b1;

        start_block(2'd0);                                    // R4 plain only
        send_cand(3'd0, 10, 1, "R4 plain");
        idle(3);

        start_block(2'd1);                                    // R2 max zeros
        send_cand(3'd0, 5, 2, "R2 diag");
        send_cand(3'd2, 20, 3, "R2 diag");
        send_cand(3'd3, 12, 4, "R2 diag");
        idle(3);

        start_block(2'd2);                                    // R2 full set
        send_cand(3'd0, 3, 5, "R2 full");
        send_cand(3'd2, 9, 6, "R2 full");
        send_cand(3'd3, 11, 7, "R2 full");
        send_cand(3'd4, 14, 8, "R2 full");
        send_cand(3'd5, 22, 9, "R2 full");
        send_cand(3'd6, 40, 10, "R2 full");
        send_cand(3'd7, 31, 11, "R2 full");
        idle(3);

        start_block(2'd2);                                    // R3 tie, R7 any order
        send_cand(3'd7, 30, 12, "R3 tie");
        send_cand(3'd5, 30, 13, "R3 tie");
        send_cand(3'd3, 30, 14, "R3 tie");
        send_cand(3'd6, 2, 15, "R3 tie");
        send_cand(3'd4, 1, 16, "R3 tie");
        send_cand(3'd2, 0, 17, "R3 tie");
        send_cand(3'd0, 29, 18, "R3 tie");
        idle(3);

        start_block(2'd1);                                    // R3 tie with plain
        send_cand(3'd3, 17, 19, "R3 tie0");
        send_cand(3'd2, 17, 20, "R3 tie0");
        send_cand(3'd0, 17, 21, "R3 tie0");
        idle(3);

        start_block(2'd1);                                    // R5 out-of-group and mode 1
        send_cand(3'd4, 64, 22, "R5 ignore");
        send_cand(3'd1, 64, 23, "R5 ignore");
        send_cand(3'd0, 8, 24, "R5 ignore");
        send_cand(3'd2, 9, 25, "R5 ignore");
        send_cand(3'd3, 7, 26, "R5 ignore");
        idle(3);

        start_block(2'd1);                                    // R6 repeat ignored
        send_cand(3'd2, 10, 27, "R6 repeat");
        send_cand(3'd2, 60, 28, "R6 repeat");
        send_cand(3'd0, 5, 29, "R6 repeat");
        send_cand(3'd3, 12, 30, "R6 repeat");
        idle(3);

        start_block(2'd0);                                    // R5 stray between blocks
        send_cand(3'd2, 50, 31, "R5 stray");
        idle(5);
        check("R8 hold mode", pick_mode, last_m);
        check("R8 hold zeros", pick_zeros, last_z);
        check("R8 idle valid", pick_valid, 0);

        start_block(2'd0);                                    // R1 all zeros
        send_cand(3'd0, 64, 32, "R1 all-zero");
        idle(3);

        start_block(2'd1);                                    // R1 no zeros
        send_cand(3'd0, 0, 33, "R1 none");
        send_cand(3'd2, 0, 34, "R1 none");
        send_cand(3'd3, 0, 35, "R1 none");
        idle(3);

        start_block(2'd3);                                    // R4 code 3 = full
        send_cand(3'd0, 4, 36, "R4 code3");
        send_cand(3'd2, 6, 37, "R4 code3");
        send_cand(3'd3, 6, 38, "R4 code3");
        send_cand(3'd4, 6, 39, "R4 code3");
        send_cand(3'd5, 6, 40, "R4 code3");
        send_cand(3'd6, 6, 41, "R4 code3");
        send_cand(3'd7, 50, 42, "R4 code3");
        idle(5);

        check("R7 scoreboard drained", q_exp.size(), 0);
        check("R8 final hold mode", pick_mode, 7);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule